// File: doc/BRIEF.md
# Output Limiter with Adaptive Release

This block limits the level of a mono stream of signed audio samples, one sample per valid cycle. It rectifies each sample and runs a one-pole level envelope from it. The envelope rises with a programmable attack coefficient and falls with a release coefficient. While the envelope sits above a programmable threshold, the block reduces the gain so that only a fixed fraction of the excess reaches the output. That fraction comes from a compression ratio set at build time. Each sample is multiplied by the resulting gain and leaves the block three cycles after it entered.

The release speed can adapt. A slow running average of the rectified level is compared against halvings of the threshold. The further the average sits below the threshold, the more the release coefficient is shifted left, up to a factor of sixteen. Brief peaks over a quiet background therefore recover quickly, while material that stays loud recovers at the programmed rate. Clearing the enable input always gives the programmed release.

Top module: `out_limiter`

## Requirements
- R1: After reset the outputs are out_valid = 0 and out_sample = 0. The envelope and the running average both start at 0, and the gain starts at unity (2^GW).
- R2: Each cycle with in_valid = 1 produces exactly one out_valid pulse 3 cycles later. Cycles with in_valid = 0 produce no output and leave the envelope, the average and the gain unchanged.
- R3: The magnitude m is |in_sample|, read as a DW-bit unsigned value (the most negative input gives 2^(DW-1)). If m > env, the envelope becomes env + floor((m - env) * attack / 2^CW).
- R4: If m <= env, the envelope becomes env - floor((env - m) * rel_eff / 2^CW), where rel_eff = release << k.
- R5: The speed-up exponent k is computed from the average before it is updated. With adaptation enabled, k counts the values i in {1,2,3,4} for which avg < (threshold >> i). With adaptation disabled, k = 0.
- R6: rel_eff saturates at 2^CW - 1, so the release is never slower than programmed and never faster than sixteen times the programmed rate.
- R7: On every valid sample the average becomes avg + ((m - avg) >>> AVG_SHIFT), using signed arithmetic with a floor shift.
- R8: When the updated envelope is at or below the threshold, the gain is unity and out_sample equals in_sample.
- R9: When the updated envelope exceeds the threshold, the gain is floor((thr + ((env - thr) >> RATIO_SHIFT)) * 2^GW / env), which is strictly below unity.
- R10: out_sample = floor(in_sample * gain / 2^GW), saturated to DW signed bits. Its magnitude never exceeds that of the input.
- R11: With identical stimulus, a loud sample that follows a short burst and a quiet stretch leaves the block larger with adaptation enabled than with it disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | DW | Signed input sample |
| cfg_threshold | input | DW | Unsigned limiting threshold |
| cfg_attack | input | CW | Attack coefficient, fraction of 2^CW |
| cfg_release | input | CW | Programmed (slowest) release coefficient |
| cfg_adapt_en | input | 1 | Enables adaptive release |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | DW | Gain-scaled signed output sample |

## Verification
The bench sends the most negative input to test magnitude overflow. A wrong rectifier would push the envelope the wrong way, or fail to push it at all, and the output would drift from the reference values. It sets a release coefficient large enough that a sixteen-fold speed-up overflows the coefficient width. A design that did not saturate would wrap to a tiny coefficient and stall the release. Idle gaps inside a quiet stretch catch a design that advances its envelope or average without a valid sample, or that emits spurious outputs. A paired run with adaptation off and then on shows whether the speed-up has the right sign. A flipped comparison would make recovery slower instead of faster.

// File: rtl/olim_pkg.sv
package olim_pkg;
   // largest release speed-up is 2**SPEEDUP_LOG2
   localparam int unsigned SPEEDUP_LOG2 = 4;
   typedef logic [2:0] rel_shift_t;
endpackage

// File: rtl/olim_adapt.sv
module olim_adapt
   import olim_pkg::*;
#(
   parameter int unsigned DW        = 16,
   parameter int unsigned AVG_SHIFT = 10,
   parameter bit          ADAPT_EN  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step_en,
   input  logic [DW-1:0] mag,
   input  logic [DW-1:0] thr,
   input  logic          adapt_en,
   output rel_shift_t    shift
);
   logic        [DW-1:0] avg_q;
   logic signed [DW:0]   diff, delta, avg_n;

   always_comb begin
      diff  = $signed({1'b0, mag}) - $signed({1'b0, avg_q});
      delta = diff >>> AVG_SHIFT;
      avg_n = $signed({1'b0, avg_q}) + delta;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       avg_q <= '0;
      else if (step_en) avg_q <= avg_n[DW-1:0];
   end

   generate
      if (ADAPT_EN) begin : g_adapt
         logic [SPEEDUP_LOG2-1:0] below;
         for (genvar i = 0; i < SPEEDUP_LOG2; i++) begin : g_cmp
            assign below[i] = avg_q < (thr >> (i + 1));
         end
         always_comb begin
            shift = '0;
            if (adapt_en)
               for (int j = 0; j < SPEEDUP_LOG2; j++)
                  shift = shift + rel_shift_t'(below[j]);
         end
      end else begin : g_fixed
         logic adapt_unused;
         assign adapt_unused = adapt_en;
         assign shift = '0;
      end
   endgenerate

   // R5
   shift_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift <= rel_shift_t'(SPEEDUP_LOG2));
   // R7
   avg_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_en && (mag > avg_q) |=> avg_q >= $past(avg_q));
   // R7
   avg_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_en && (mag < avg_q) |=> (avg_q < $past(avg_q)) && (avg_q >= $past(mag)));
   // R2
   avg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> $stable(avg_q));
endmodule

// File: rtl/olim_envelope.sv
module olim_envelope
   import olim_pkg::*;
#(
   parameter int unsigned DW = 16,
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step_en,
   input  logic [DW-1:0] mag,
   input  logic [CW-1:0] atk,
   input  logic [CW-1:0] rel,
   input  rel_shift_t    shift,
   output logic [DW-1:0] env_q
);
   localparam int unsigned RW = CW + SPEEDUP_LOG2;
   localparam int unsigned PW = DW + CW;

   logic [RW-1:0] rel_wide;
   logic [CW-1:0] rel_eff, coef;
   logic [PW-1:0] prod;
   logic [DW-1:0] diff, step, env_n;
   logic          rising;

   always_comb begin
      rel_wide = {{SPEEDUP_LOG2{1'b0}}, rel} << shift;
      rel_eff  = (|rel_wide[RW-1:CW]) ? '1 : rel_wide[CW-1:0];
      rising   = mag > env_q;
      diff     = rising ? (mag - env_q) : (env_q - mag);
      coef     = rising ? atk : rel_eff;
      prod     = {{CW{1'b0}}, diff} * {{DW{1'b0}}, coef};
      step     = DW'(prod >> CW);
      env_n    = rising ? (env_q + step) : (env_q - step);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       env_q <= '0;
      else if (step_en) env_q <= env_n;
   end

   // R3
   env_attack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_en && (mag > env_q) |=> (env_q >= $past(env_q)) && (env_q <= $past(mag)));
   // R4
   env_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_en && (mag <= env_q) |=> (env_q <= $past(env_q)) && (env_q >= $past(mag)));
   // R6
   rel_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rel_eff >= rel);
   // R2
   env_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> $stable(env_q));
endmodule

// File: rtl/olim_gain.sv
module olim_gain #(
   parameter int unsigned DW          = 16,
   parameter int unsigned GW          = 15,
   parameter int unsigned RATIO_SHIFT = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          calc_en,
   input  logic [DW-1:0] env,
   input  logic [DW-1:0] thr,
   output logic [GW:0]   gain_q
);
   localparam int unsigned NW    = DW + GW;
   localparam logic [GW:0] UNITY = {1'b1, {GW{1'b0}}};

   logic [DW-1:0] excess, target;
   logic [NW-1:0] num, den, quo;
   logic [GW:0]   gain_n;
   logic          over;

   always_comb begin
      over   = env > thr;
      excess = env - thr;
      target = thr + (excess >> RATIO_SHIFT);
      num    = {target, {GW{1'b0}}};
      den    = {{GW{1'b0}}, env};
      quo    = over ? (num / den) : '0;
      gain_n = over ? (GW+1)'(quo) : UNITY;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       gain_q <= UNITY;
      else if (calc_en) gain_q <= gain_n;
   end

   // R8
   unity_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
      calc_en && (env <= thr) |=> gain_q == UNITY);
   // R9
   reduce_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
      calc_en && (env > thr) |=> gain_q < UNITY);
   // R2
   gain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !calc_en |=> $stable(gain_q));
endmodule

// File: rtl/out_limiter.sv
module out_limiter
   import olim_pkg::*;
#(
   parameter int unsigned DW          = 16,
   parameter int unsigned CW          = 16,
   parameter int unsigned GW          = 15,
   parameter int unsigned RATIO_SHIFT = 3,
   parameter int unsigned AVG_SHIFT   = 10,
   parameter bit          ADAPT_EN    = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [DW-1:0] in_sample,
   input  logic [DW-1:0] cfg_threshold,
   input  logic [CW-1:0] cfg_attack,
   input  logic [CW-1:0] cfg_release,
   input  logic          cfg_adapt_en,
   output logic          out_valid,
   output logic [DW-1:0] out_sample
);
   localparam int unsigned PW = DW + GW + 2;
   localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
   localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

   generate
      if (DW < 8 || DW > 32) begin : g_bad_dw
         $error("out_limiter: DW must lie in 8..32");
      end
      if (CW < 4 || CW > 24) begin : g_bad_cw
         $error("out_limiter: CW must lie in 4..24");
      end
      if (GW < 4 || GW > 24) begin : g_bad_gw
         $error("out_limiter: GW must lie in 4..24");
      end
      if (RATIO_SHIFT < 1 || RATIO_SHIFT > 8) begin : g_bad_ratio
         $error("out_limiter: RATIO_SHIFT must lie in 1..8");
      end
      if (AVG_SHIFT < 1 || AVG_SHIFT >= DW) begin : g_bad_avg
         $error("out_limiter: AVG_SHIFT must lie in 1..DW-1");
      end
   endgenerate

   logic [DW-1:0] mag, env, x1, x2;
   logic [GW:0]   gain;
   logic          v1, v2;
   rel_shift_t    shift;

   always_comb mag = in_sample[DW-1] ? (~in_sample + DW'(1)) : in_sample;

   olim_adapt #(.DW(DW), .AVG_SHIFT(AVG_SHIFT), .ADAPT_EN(ADAPT_EN)) u_adapt (
      .clk(clk), .rst_n(rst_n), .step_en(in_valid), .mag(mag),
      .thr(cfg_threshold), .adapt_en(cfg_adapt_en), .shift(shift));

   olim_envelope #(.DW(DW), .CW(CW)) u_env (
      .clk(clk), .rst_n(rst_n), .step_en(in_valid), .mag(mag),
      .atk(cfg_attack), .rel(cfg_release), .shift(shift), .env_q(env));

   olim_gain #(.DW(DW), .GW(GW), .RATIO_SHIFT(RATIO_SHIFT)) u_gain (
      .clk(clk), .rst_n(rst_n), .calc_en(v1), .env(env),
      .thr(cfg_threshold), .gain_q(gain));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1 <= 1'b0; v2 <= 1'b0; x1 <= '0; x2 <= '0;
      end else begin
         v1 <= in_valid;
         v2 <= v1;
         if (in_valid) x1 <= in_sample;
         if (v1)       x2 <= x1;
      end
   end

   logic signed [PW-1:0] prod, scaled;
   logic [DW-1:0] out_n;
   logic          fits;

   always_comb begin
      prod   = $signed({{(GW+2){x2[DW-1]}}, x2}) * $signed({{(DW+1){1'b0}}, gain});
      scaled = prod >>> GW;
      fits   = (scaled[PW-1:DW-1] == '0) || (scaled[PW-1:DW-1] == '1);
      out_n  = fits ? scaled[DW-1:0] : (scaled[PW-1] ? SMIN : SMAX);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_sample <= '0;
      end else begin
         out_valid <= v2;
         if (v2) out_sample <= out_n;
      end
   end

   logic [DW-1:0] omag, xmag;
   always_comb begin
      omag = out_sample[DW-1] ? (~out_sample + DW'(1)) : out_sample;
      xmag = x2[DW-1] ? (~x2 + DW'(1)) : x2;
   end

   // R2
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##3 out_valid);
   // R2
   no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> ##3 !out_valid);
   // R10
   out_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> omag <= $past(xmag));
endmodule

// File: tb/out_limiter_tb.sv
`timescale 1ns/1ps
module out_limiter_tb;
   localparam int DW = 16;

   typedef struct {
      int     val;
      longint at;
      string  req;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_sample = '0;
   logic [DW-1:0] thr = 16'd8000;
   logic [15:0]   atk = 16'h4000;
   logic [15:0]   rel = 16'h0200;
   logic          adapt = 1'b0;
   logic          out_valid;
   logic [DW-1:0] out_sample;

   int     chk = 0, err = 0;
   longint cyc = 0;
   int     env_m = 0, avg_m = 0;
   int     last_out = 0;
   string  phase = "R1";
   exp_t   exp_q[$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   out_limiter u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .cfg_threshold(thr), .cfg_attack(atk), .cfg_release(rel),
      .cfg_adapt_en(adapt), .out_valid(out_valid), .out_sample(out_sample));

   task automatic check(input string req, input int act, input int expv);
      chk++;
      if (act != expv) begin
         err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            chk++; err++;
            $display("FAIL R2 unexpected output actual=%0d expected=none",
                     $signed(out_sample));
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            last_out = int'($signed(out_sample));
            check(e.req, last_out, e.val);
            check("R2 latency", int'(cyc), int'(e.at));
         end
      end
   end

   // reference model taken from the requirement formulas
   task automatic send(input int x);
      int m, k, reff, g, tgt, y;
      exp_t e;
      m = (x < 0) ? -x : x;
      k = 0;
      if (adapt)
         for (int i = 1; i <= 4; i++) if (avg_m < (int'(thr) >> i)) k++;
      reff = int'(rel) << k;
      if (reff > 65535) reff = 65535;
      if (m > env_m) env_m = env_m + int'((longint'(m - env_m) * longint'(atk)) >>> 16);
      else           env_m = env_m - int'((longint'(env_m - m) * longint'(reff)) >>> 16);
      avg_m = avg_m + ((m - avg_m) >>> 10);
      if (env_m <= int'(thr)) g = 32768;
      else begin
         tgt = int'(thr) + ((env_m - int'(thr)) >> 3);
         g = int'((longint'(tgt) <<< 15) / longint'(env_m));
      end
      y = int'((longint'(x) * longint'(g)) >>> 15);
      if (y > 32767) y = 32767;
      if (y < -32768) y = -32768;
      e.val = y; e.at = cyc + 3; e.req = phase;
      exp_q.push_back(e);
      in_valid = 1'b1;
      in_sample = DW'(x);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      in_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; in_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      env_m = 0; avg_m = 0;
      @(negedge clk);
      // R1 reset state at the ports
      check("R1 out_valid", int'(out_valid), 0);
      check("R1 out_sample", int'($signed(out_sample)), 0);
   endtask

   task automatic recovery_run(input logic en, output int result);
      adapt = en; atk = 16'h8000; rel = 16'h0100; thr = 16'd8000;
      do_reset();
      phase = "R11 run";
      for (int i = 0; i < 40; i++) send((i % 2) ? -30000 : 30000);
      for (int i = 0; i < 300; i++) send((i % 2) ? -100 : 100);
      send(20000);
      idle(6);
      result = last_out;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk++; err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", chk, err);
      $finish;
   end

   initial begin
      int off_out, on_out;
      @(negedge clk);
      do_reset();

      // R8: envelope stays under threshold, output equals input
      phase = "R8 unity";
      for (int i = 1; i <= 20; i++) send((i % 2) ? i * 300 : -i * 300);
      idle(5);

      // R3: loud burst including the most negative code
      phase = "R3 attack";
      for (int i = 0; i < 30; i++) send((i % 3 == 0) ? -32768 : 30000);
      idle(5);

      // R4 with R2: quiet tail broken by idle gaps
      phase = "R4 release";
      for (int i = 0; i < 60; i++) begin
         send((i % 2) ? -200 : 200);
         if (i % 5 == 4) idle(3);
      end
      idle(5);

      // R9 and R10: steady level over threshold
      phase = "R9 R10 gain";
      for (int i = 0; i < 30; i++) send((i % 2) ? 25000 : -20000);
      idle(5);

      // R5, R6, R7: adaptive release with a coefficient that saturates
      adapt = 1'b1; rel = 16'h2000;
      do_reset();
      phase = "R6 saturate";
      for (int i = 0; i < 10; i++) send(30000);
      phase = "R5 R7 adapt";
      for (int i = 0; i < 40; i++) send((i % 2) ? -50 : 50);
      idle(5);

      // R11: paired recovery comparison
      recovery_run(1'b0, off_out);
      recovery_run(1'b1, on_out);
      chk++;
      if (!(on_out > off_out)) begin
         err++;
         $display("FAIL R11 actual=%0d expected greater than %0d", on_out, off_out);
      end

      check("R2 drained", exp_q.size(), 0);
      $display("  CHECKS %0d ERRORS %0d", chk, err);
      $finish;
   end
endmodule